// File: doc/BRIEF.md
# Flow-Control Frame Builder

This block turns a single flow-control request into a complete MAC-control frame and streams it out over a valid/ready byte-lane interface. Each request names a queue and says whether that queue wants the link partner to stop (XOFF) or resume (XON). The builder forms one of two frame types from the request: a classic Pause frame with one timer, or a priority flow-control frame. The priority frame carries a class-enable vector and eight per-class timers.

The frame is emitted from the first destination-address byte through the end of zero padding, 60 bytes in total. Preamble, FCS, the interframe gap and arbitration against user traffic are handled downstream. The destination address, source address, per-queue quanta and the frame-type select come from configuration inputs. They are captured in the cycle a request is accepted, so reprogramming them while a frame is in flight cannot corrupt that frame. The configuration registers upstream reset to destination 01-80-C2-00-00-01, source E1-00-CB-FC-5A-DD, quanta FFFF for every queue, and the select set to priority framing.

Top module: `fc_frame_builder`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `req_ready` is 1.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a rising edge. `req_ready` stays 0 and further requests are ignored from that edge until the edge that accepts the last beat. `out_valid` rises in the cycle after acceptance and falls in the cycle after the last beat is accepted.
- R3: Every frame is 60 bytes, sent as 60/BEAT_BYTES beats (BEAT_BYTES must divide 60). `out_sop` is 1 only on the first beat and `out_eop` is 1 only on the last beat.
- R4: Frame byte n travels in beat n/BEAT_BYTES on bits [8*(n%BEAT_BYTES)+7 : 8*(n%BEAT_BYTES)]. Bytes 0-5 hold the destination address and bytes 6-11 hold the source address, both most significant byte first. Bytes 12-13 are 0x88, 0x08.
- R5: A Pause frame has opcode bytes 14-15 = 0x00, 0x01, its timer in bytes 16-17 (high byte first), and zero in bytes 18-59.
- R6: A priority frame has opcode bytes 14-15 = 0x01, 0x01. Bytes 16-17 hold a 16-bit class-enable vector, high byte first, with only bit q set for queue q. Class k's timer is in bytes 18+2k and 19+2k, high byte first. Every other class timer and bytes 34-59 are zero.
- R7: For queue 0 the select input picks Pause (0) or priority (1) framing. Every other queue always produces a priority frame.
- R8: For XOFF the timer value is the requesting queue's quanta, `cfg_quanta[16q+15:16q]`. For XON the timer value is zero.
- R9: Address, quanta, select, queue and XON/XOFF values are sampled at acceptance. Changes to them before the last beat is accepted do not alter the frame.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_sop`, `out_eop` and `out_valid` hold their values at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Builder idle, can take a request |
| req_queue | input | QW | Requesting queue / priority class |
| req_xoff | input | 1 | 1 = XOFF, 0 = XON |
| cfg_quanta | input | 16*NUM_QUEUES | Per-queue quanta, queue q in bits [16q+15:16q] |
| cfg_dst_mac | input | 48 | Destination address |
| cfg_src_mac | input | 48 | Source address |
| cfg_pfc_sel | input | 1 | Queue 0 framing: 0 Pause, 1 priority |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Sink accepts beat |
| out_data | output | 8*BEAT_BYTES | Beat data, lowest lane first on the wire |
| out_sop | output | 1 | First beat of frame |
| out_eop | output | 1 | Last beat of frame |

## Verification
The bench targets three framing cases. The first is queue 0 with the select at 0: a builder that ignores the select would send a priority frame. The second is a non-zero queue with the select at 0: a builder that applies the select to every queue would send a Pause frame. The third is an XON request: a builder that copies the quanta would keep the partner paused. The bench also reprograms every configuration input and presents a second request while a frame is stalled mid-flight by a random sink. A builder that reads live configuration, accepts while busy, or lets data move under backpressure shows mismatched bytes or a lost frame. The high classes 5-7 are exercised to catch class-vector bit and timer slot placement off by a byte.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

    localparam int FRAME_BYTES = 60;
    localparam int PFC_CLASSES = 8;
    localparam int CLASS_W     = 3;

    // byte offsets inside the frame
    localparam int OFS_SRC    = 6;
    localparam int OFS_TYPE   = 12;
    localparam int OFS_OPC    = 14;
    localparam int OFS_ARG    = 16;
    localparam int OFS_TIMERS = 18;
    localparam int OFS_PAD    = OFS_TIMERS + 2 * PFC_CLASSES;

    localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;
    localparam logic [15:0] OPC_PAUSE     = 16'h0001;
    localparam logic [15:0] OPC_PFC       = 16'h0101;

    // values the configuration registers take at reset
    localparam logic [47:0] DEF_DST_MAC = 48'h0180_C200_0001;
    localparam logic [47:0] DEF_SRC_MAC = 48'hE100_CBFC_5ADD;
    localparam logic [15:0] DEF_QUANTA  = 16'hFFFF;

    typedef struct packed {
        logic [47:0]        dst;
        logic [47:0]        src;
        logic               pfc;
        logic [CLASS_W-1:0] cls;
        logic [15:0]        timer;
    } fcf_fields_t;

endpackage

// File: rtl/fcf_capture.sv
module fcf_capture
    import fcf_pkg::*;
#(
    parameter int NUM_QUEUES = 8,
    parameter int QW         = $clog2(NUM_QUEUES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [QW-1:0]           req_queue,
    input  logic                    req_xoff,
    input  logic [NUM_QUEUES*16-1:0] cfg_quanta,
    input  logic [47:0]             cfg_dst_mac,
    input  logic [47:0]             cfg_src_mac,
    input  logic                    cfg_pfc_sel,
    output fcf_fields_t             fields
);

    typedef struct packed {
        fcf_fields_t f;
    } cap_state_t;

    cap_state_t  st_d;
    cap_state_t  st_q;
    logic [15:0] quanta_sel;

    always_comb begin
        quanta_sel = '0;
        for (int i = 0; i < NUM_QUEUES; i++) begin
            if (req_queue == QW'(i)) begin
                quanta_sel = cfg_quanta[i*16 +: 16];
            end
        end

        st_d = st_q;
        if (load) begin
            st_d.f.dst   = cfg_dst_mac;
            st_d.f.src   = cfg_src_mac;
            st_d.f.cls   = CLASS_W'(req_queue);
            st_d.f.pfc   = (req_queue != '0) || cfg_pfc_sel;
            st_d.f.timer = req_xoff ? quanta_sel : 16'h0000;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields = st_q.f;

endmodule

// File: rtl/fcf_beat_ctrl.sv
module fcf_beat_ctrl #(
    parameter int BEATS = 15,
    parameter int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          out_ready,
    output logic          req_ready,
    output logic          load,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic [BW-1:0] beat_idx
);

    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    typedef struct packed {
        logic          busy;
        logic [BW-1:0] beat;
    } ctrl_state_t;

    ctrl_state_t st_d;
    ctrl_state_t st_q;
    logic        at_last;

    always_comb begin
        at_last = (st_q.beat == LAST_BEAT);
        load    = !st_q.busy && req_valid;
        st_d    = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.beat = '0;
        end else if (st_q.busy && out_ready) begin
            if (at_last) begin
                st_d.busy = 1'b0;
                st_d.beat = '0;
            end else begin
                st_d.beat = st_q.beat + BW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.busy;
    assign out_valid = st_q.busy;
    assign out_sop   = st_q.busy && (st_q.beat == '0);
    assign out_eop   = st_q.busy && at_last;
    assign beat_idx  = st_q.beat;

endmodule

// File: rtl/fcf_lane_byte.sv
module fcf_lane_byte
    import fcf_pkg::*;
#(
    parameter int LANE       = 0,
    parameter int BEAT_BYTES = 4,
    parameter int BW         = 4
) (
    input  fcf_fields_t   fields,
    input  logic [BW-1:0] beat_idx,
    output logic [7:0]    byte_o
);

    int          pos;
    int          rel;
    logic [15:0] class_vec;

    always_comb begin
        pos       = BEAT_BYTES * int'(beat_idx) + LANE;
        rel       = pos - OFS_TIMERS;
        class_vec = 16'(16'h0001 << fields.cls);
        byte_o    = 8'h00;

        if (pos < OFS_SRC) begin
            byte_o = 8'(fields.dst >> (8 * (OFS_SRC - 1 - pos)));
        end else if (pos < OFS_TYPE) begin
            byte_o = 8'(fields.src >> (8 * (OFS_TYPE - 1 - pos)));
        end else if (pos == OFS_TYPE) begin
            byte_o = MAC_CTRL_TYPE[15:8];
        end else if (pos == OFS_TYPE + 1) begin
            byte_o = MAC_CTRL_TYPE[7:0];
        end else if (pos == OFS_OPC) begin
            byte_o = fields.pfc ? OPC_PFC[15:8] : OPC_PAUSE[15:8];
        end else if (pos == OFS_OPC + 1) begin
            byte_o = fields.pfc ? OPC_PFC[7:0] : OPC_PAUSE[7:0];
        end else if (pos == OFS_ARG) begin
            byte_o = fields.pfc ? class_vec[15:8] : fields.timer[15:8];
        end else if (pos == OFS_ARG + 1) begin
            byte_o = fields.pfc ? class_vec[7:0] : fields.timer[7:0];
        end else if (fields.pfc && pos >= OFS_TIMERS && pos < OFS_PAD) begin
            if ((rel >> 1) == int'(fields.cls)) begin
                byte_o = rel[0] ? fields.timer[7:0] : fields.timer[15:8];
            end
        end
    end

endmodule

// File: rtl/fc_frame_builder.sv
module fc_frame_builder
    import fcf_pkg::*;
#(
    parameter int NUM_QUEUES = 8,
    parameter int BEAT_BYTES = 4,
    parameter int QW         = $clog2(NUM_QUEUES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [QW-1:0]            req_queue,
    input  logic                     req_xoff,
    input  logic [NUM_QUEUES*16-1:0] cfg_quanta,
    input  logic [47:0]              cfg_dst_mac,
    input  logic [47:0]              cfg_src_mac,
    input  logic                     cfg_pfc_sel,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [8*BEAT_BYTES-1:0]  out_data,
    output logic                     out_sop,
    output logic                     out_eop
);

    localparam int BEATS = FRAME_BYTES / BEAT_BYTES;
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic          load;
    logic [BW-1:0] beat_idx;
    fcf_fields_t   fields;

    fcf_beat_ctrl #(
        .BEATS (BEATS),
        .BW    (BW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .out_ready (out_ready),
        .req_ready (req_ready),
        .load      (load),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .beat_idx  (beat_idx)
    );

    fcf_capture #(
        .NUM_QUEUES (NUM_QUEUES),
        .QW         (QW)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .req_queue   (req_queue),
        .req_xoff    (req_xoff),
        .cfg_quanta  (cfg_quanta),
        .cfg_dst_mac (cfg_dst_mac),
        .cfg_src_mac (cfg_src_mac),
        .cfg_pfc_sel (cfg_pfc_sel),
        .fields      (fields)
    );

    for (genvar l = 0; l < BEAT_BYTES; l++) begin : g_lane
        fcf_lane_byte #(
            .LANE       (l),
            .BEAT_BYTES (BEAT_BYTES),
            .BW         (BW)
        ) u_lane (
            .fields   (fields),
            .beat_idx (beat_idx),
            .byte_o   (out_data[8*l +: 8])
        );
    end

endmodule

// File: rtl/fc_frame_builder_chk.sv
module fc_frame_builder_chk #(
    parameter int BEAT_BYTES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [8*BEAT_BYTES-1:0] out_data,
    input logic                    out_sop,
    input logic                    out_eop
);

    localparam int BEATS = 60 / BEAT_BYTES;
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [BW-1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (out_valid && out_ready) begin
            seen <= out_eop ? '0 : seen + BW'(1);
        end
    end

    assert_sop_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid && out_sop));

    assert_idle_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eop) |=> !out_valid);

    assert_eop_position_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_eop == (seen == BW'(BEATS - 1))));

    assert_sop_position_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == (seen == '0)));

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

endmodule

bind fc_frame_builder fc_frame_builder_chk #(
    .BEAT_BYTES (BEAT_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/fc_frame_builder_test.sv
module fc_frame_builder_test;

    localparam int CLK_PERIOD = 10;
    localparam int NQ         = 8;
    localparam int BB         = 4;
    localparam int NBEATS     = 60 / BB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_queue = '0;
    logic              req_xoff = 1'b0;
    logic [NQ*16-1:0]  cfg_quanta = '1;
    logic [47:0]       cfg_dst_mac = 48'h0180_C200_0001;
    logic [47:0]       cfg_src_mac = 48'hE100_CBFC_5ADD;
    logic              cfg_pfc_sel = 1'b1;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [8*BB-1:0]   out_data;
    logic              out_sop;
    logic              out_eop;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    bit        m_busy = 0;
    int        m_beat = 0;
    bit        m_pfc = 0;
    int        m_q = 0;
    bit        m_r9 = 0;
    bit        m_stalled = 0;
    bit [7:0]  exp_b [60];

    // stimulus controls
    bit        stall_on = 0;
    bit        mid_change = 0;
    bit [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fc_frame_builder #(
        .NUM_QUEUES (NQ),
        .BEAT_BYTES (BB)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_queue   (req_queue),
        .req_xoff    (req_xoff),
        .cfg_quanta  (cfg_quanta),
        .cfg_dst_mac (cfg_dst_mac),
        .cfg_src_mac (cfg_src_mac),
        .cfg_pfc_sel (cfg_pfc_sel),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_sop     (out_sop),
        .out_eop     (out_eop)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // expected frame, written byte by byte from the requirement text
    task automatic build_frame(input int q, input bit xoff, input bit psel,
                               input logic [47:0] da, input logic [47:0] sa,
                               input logic [NQ*16-1:0] qt);
        logic [15:0] t;
        m_pfc = (q != 0) || psel;
        m_q   = q;
        t     = xoff ? qt[16*q +: 16] : 16'h0000;
        foreach (exp_b[i]) exp_b[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin
            exp_b[i]     = da[8*(5-i) +: 8];
            exp_b[6 + i] = sa[8*(5-i) +: 8];
        end
        exp_b[12] = 8'h88;
        exp_b[13] = 8'h08;
        exp_b[15] = 8'h01;
        if (m_pfc) begin
            exp_b[14] = 8'h01;
            if (q >= 8) exp_b[16] = 8'(1 << (q - 8));
            else        exp_b[17] = 8'(1 << q);
            exp_b[18 + 2*q] = t[15:8];
            exp_b[19 + 2*q] = t[7:0];
        end else begin
            exp_b[16] = t[15:8];
            exp_b[17] = t[7:0];
        end
    endtask

    function automatic string tag_of(input int i);
        string s;
        if (i < 14)                                       s = "R4";
        else if (i == 14)                                 s = "R7";
        else if (i == 15)                                 s = m_pfc ? "R6" : "R5";
        else if (i < 18)                                  s = m_pfc ? "R6" : "R8";
        else if (m_pfc && i < 34 && ((i - 18) / 2) == m_q) s = "R8";
        else                                              s = m_pfc ? "R6" : "R5";
        if (m_r9)      s = {s, " R9"};
        if (m_stalled) s = {s, " R10"};
        return s;
    endfunction

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(out_valid === 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
            chk(req_ready === 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
            m_busy = 0;
        end else begin
            chk(out_valid === m_busy, "R2", "out_valid", 64'(out_valid), 64'(m_busy));
            chk(req_ready === !m_busy, "R2", "req_ready", 64'(req_ready), 64'(!m_busy));
            if (m_busy && out_valid) begin
                for (int l = 0; l < BB; l++) begin
                    int n;
                    n = m_beat * BB + l;
                    chk(out_data[8*l +: 8] === exp_b[n], tag_of(n),
                        $sformatf("frame byte %0d", n), 64'(out_data[8*l +: 8]), 64'(exp_b[n]));
                end
                chk(out_sop === (m_beat == 0), "R3", "out_sop", 64'(out_sop), 64'(m_beat == 0));
                chk(out_eop === (m_beat == NBEATS - 1), "R3", "out_eop",
                    64'(out_eop), 64'(m_beat == NBEATS - 1));
            end
            // what the coming edge does
            if (m_busy) begin
                if (out_ready) begin
                    m_stalled = 0;
                    if (m_beat == NBEATS - 1) m_busy = 0;
                    else m_beat++;
                end else begin
                    m_stalled = 1;
                end
            end else if (req_valid) begin
                build_frame(int'(req_queue), req_xoff, cfg_pfc_sel, cfg_dst_mac, cfg_src_mac, cfg_quanta);
                m_r9      = mid_change;
                m_stalled = 0;
                m_busy    = 1;
                m_beat    = 0;
            end
        end
    end

    // sink readiness
    always @(posedge clk) begin
        #1;
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_on ? (lfsr[0] | lfsr[5]) : 1'b1;
    end

    task automatic send(input int q, input bit xoff);
        @(posedge clk);
        #1;
        req_queue = 3'(q);
        req_xoff  = xoff;
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle;
        do @(posedge clk); while (m_busy);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R5 R7: queue 0 with select 0 -> Pause, default addresses, XOFF FFFF
        cfg_pfc_sel = 1'b0;
        send(0, 1'b1);
        wait_idle();

        // R8: XON Pause frame carries zero timer
        cfg_quanta[15:0] = 16'h1234;
        send(0, 1'b0);
        wait_idle();

        // R6 R7: queue 0 with select 1 -> priority frame, class 0
        cfg_pfc_sel = 1'b1;
        send(0, 1'b1);
        wait_idle();

        // R7: queue 5 stays priority even with select 0
        cfg_pfc_sel = 1'b0;
        cfg_quanta[16*5 +: 16] = 16'hA55A;
        send(5, 1'b1);
        wait_idle();

        // R8: XON on class 6
        send(6, 1'b0);
        wait_idle();

        // R10: backpressure on class 7 with other addresses
        stall_on    = 1;
        cfg_dst_mac = 48'h0A1B_2C3D_4E5F;
        cfg_src_mac = 48'h6071_8293_A4B5;
        cfg_quanta[16*7 +: 16] = 16'h00C3;
        send(7, 1'b1);
        wait_idle();

        // R9: every input changes right after acceptance
        mid_change = 1;
        cfg_quanta[16*3 +: 16] = 16'h7E81;
        send(3, 1'b1);
        cfg_dst_mac = 48'hFFFF_FFFF_FFFF;
        cfg_src_mac = 48'h0;
        cfg_quanta  = '0;
        cfg_pfc_sel = 1'b1;
        req_queue   = 3'd0;
        req_xoff    = 1'b0;
        wait_idle();
        mid_change = 0;

        // R2: second request held while first frame is stalled
        cfg_quanta  = {NQ{16'h5A0F}};
        cfg_pfc_sel = 1'b0;
        send(2, 1'b1);
        send(0, 1'b1);
        wait_idle();
        stall_on = 0;

        repeat (4) @(posedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        report();
        $finish;
    end

endmodule